// File: doc/BRIEF.md
# Palette DAC Register Interface

This block is a small memory-mapped slave that fills a 256-entry colour palette. Software does not address each entry directly. It writes a palette index to one register. It then streams colour bytes through a second register. An internal three-phase sequencer routes each byte in turn to the red, green and blue component of the current entry. After the blue byte, the index moves on by one, so a run of consecutive entries can be loaded without rewriting the index.

The display datapath reads the palette through a separate combinational port. It presents an index and receives the packed colour for that index. Register reads carry no information and return zero. Only whole 32-bit accesses are meaningful, and the colour or index byte always sits in the top byte of the written word.

Top module: `pal_dac_regs`

## Requirements
- R1: The register window spans 16 bytes and is decoded on addr[3:2]. Offset 0x0 is the index register and offset 0x4 is the data register. Writes to offsets 0x8 and 0xC change neither the palette, the current index nor the component phase.
- R2: A write to the index register sets the current palette index to wdata[31:24]. The lower 24 bits of the word are ignored.
- R3: Writes to the data register store wdata[31:24] into the red, green and blue component of the current entry, in that order. The read port presents an entry as {red, green, blue}, with red in bits 23:16 and blue in bits 7:0.
- R4: The data write that stores blue advances the current index by one, wrapping from 255 to 0.
- R5: After reset, entries 0 to 254 read 0x000000 and entry 255 reads 0xFFFFFF.
- R6: rdata reads zero at every offset.
- R7: A write to the index register returns the sequencer to the red phase, even in the middle of a triple.
- R8: A component written on a clock edge appears on pix_rgb for a matching pix_idx from that edge onward, which is the cycle after the write is presented. It does not appear before that edge.
- R9: While data writes continue, the sequencer keeps cycling red, green, blue, red, and so fills successive entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one 32-bit word |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte offset within the register window |
| wdata | input | 32 | Write data; the payload is in bits 31:24 |
| rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Palette index from the display datapath |
| pix_rgb | output | 24 | Colour of entry pix_idx, as {red, green, blue} |

## Verification
The assertions assume that wr_en is a clean single-cycle strobe with a stable addr and wdata around the sampling edge. They also assume the display side holds pix_idx steady across the edge that follows a red write. The bench drives every input only at falling edges and drops wr_en after one cycle. It keeps pix_idx constant while each write retires, so each check sees one settled write. The only exception is the deliberate before-edge probe for R8, which is read between edges and never at one.

// File: rtl/pal_dac_regs.sv
module pal_dac_regs #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb
);
  localparam int DEPTH = 1 << IDX_W;

  typedef enum logic [1:0] {PH_R = 2'd0, PH_G = 2'd1, PH_B = 2'd2} phase_t;

  logic [COMP_W-1:0] red [DEPTH];
  logic [COMP_W-1:0] grn [DEPTH];
  logic [COMP_W-1:0] blu [DEPTH];
  logic [IDX_W-1:0]  cur_idx;
  phase_t            phase;

  wire sel_idx  = wr_en && (addr[3:2] == 2'd0);
  wire sel_data = wr_en && (addr[3:2] == 2'd1);
  wire [COMP_W-1:0] payload = wdata[DATA_W-1 -: COMP_W];

  // register reads carry no data; rd_en is accepted and has no side effect
  assign rdata   = '0;
  assign pix_rgb = {red[pix_idx], grn[pix_idx], blu[pix_idx]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx <= '0;
      phase   <= PH_R;
    end else if (sel_idx) begin
      cur_idx <= wdata[DATA_W-1 -: IDX_W];
      phase   <= PH_R;
    end else if (sel_data) begin
      case (phase)
        PH_R:    phase <= PH_G;
        PH_G:    phase <= PH_B;
        default: begin
          phase   <= PH_R;
          cur_idx <= cur_idx + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        red[i] <= (i == DEPTH-1) ? '1 : '0;
        grn[i] <= (i == DEPTH-1) ? '1 : '0;
        blu[i] <= (i == DEPTH-1) ? '1 : '0;
      end
    end else if (sel_data) begin
      case (phase)
        PH_R:    red[cur_idx] <= payload;
        PH_G:    grn[cur_idx] <= payload;
        default: blu[cur_idx] <= payload;
      endcase
    end
  end

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_idx |=> cur_idx == $past(wdata[DATA_W-1 -: IDX_W])); // R2

  AST_PHASE_RED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_idx |=> phase == PH_R); // R7

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_data && phase == PH_B) |=> cur_idx == $past(cur_idx) + 1'b1); // R4

  AST_PHASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_data && phase != PH_B) |=> (phase == $past(phase) + 2'd1) && $stable(cur_idx)); // R9

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_idx || sel_data) |=> $stable(cur_idx) && $stable(phase)); // R1

  AST_RED_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_data && phase == PH_R && pix_idx == cur_idx) |=>
      (pix_idx != $past(pix_idx)) || pix_rgb[3*COMP_W-1 -: COMP_W] == $past(payload)); // R8

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rdata == '0); // R6
endmodule

// File: tb/pal_dac_regs_test.sv
module pal_dac_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic        rd_en = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [7:0]  pix_idx = 0;
  logic [23:0] pix_rgb;
  int errors = 0;
  int checks = 0;

  pal_dac_regs uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb));

  always #10 clk = ~clk;

  // vector: {req[3:0], kind[3:0], val[7:0], idx[7:0], exp[23:0]}
  // kind 0: index write, 1: data write, 2: check entry idx == exp
  localparam int NV = 21;
  localparam logic [47:0] VEC [NV] = '{
    {4'd2, 4'd0, 8'h10, 8'h00, 24'h0},        // R2 index 0x10
    {4'd3, 4'd1, 8'h11, 8'h00, 24'h0},        // R3 red
    {4'd3, 4'd1, 8'h22, 8'h00, 24'h0},        // R3 green
    {4'd3, 4'd1, 8'h33, 8'h00, 24'h0},        // R3 blue
    {4'd3, 4'd2, 8'h00, 8'h10, 24'h112233},   // R3 entry filled
    {4'd4, 4'd2, 8'h00, 8'h11, 24'h000000},   // R4 next untouched
    {4'd4, 4'd1, 8'h44, 8'h00, 24'h0},        // R4 auto index
    {4'd4, 4'd1, 8'h55, 8'h00, 24'h0},
    {4'd4, 4'd1, 8'h66, 8'h00, 24'h0},
    {4'd4, 4'd2, 8'h00, 8'h11, 24'h445566},   // R4 went to 0x11
    {4'd7, 4'd0, 8'h20, 8'h00, 24'h0},        // R7 index 0x20
    {4'd7, 4'd1, 8'hAA, 8'h00, 24'h0},        // R7 red only
    {4'd7, 4'd0, 8'h20, 8'h00, 24'h0},        // R7 restart
    {4'd7, 4'd1, 8'h01, 8'h00, 24'h0},
    {4'd7, 4'd1, 8'h02, 8'h00, 24'h0},
    {4'd7, 4'd1, 8'h03, 8'h00, 24'h0},
    {4'd7, 4'd2, 8'h00, 8'h20, 24'h010203},   // R7 red overwritten
    {4'd9, 4'd1, 8'hC1, 8'h00, 24'h0},        // R9 keeps cycling
    {4'd9, 4'd1, 8'hC2, 8'h00, 24'h0},
    {4'd9, 4'd1, 8'hC3, 8'h00, 24'h0},
    {4'd9, 4'd2, 8'h00, 8'h21, 24'hC1C2C3}    // R9 entry 0x21
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] v);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = {v, 24'h5A5A5A};
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic peek(logic [7:0] i, logic [23:0] exp, string req);
    pix_idx = i;
    #1;
    chk(req, {8'h0, pix_rgb}, {8'h0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(8'h00, 24'h000000, "R5");
    peek(8'h80, 24'h000000, "R5");
    peek(8'hFE, 24'h000000, "R5");
    peek(8'hFF, 24'hFFFFFF, "R5");

    for (int k = 0; k < NV; k++) begin
      case (VEC[k][43:40])
        4'd0: wr(4'h0, VEC[k][39:32]);
        4'd1: wr(4'h4, VEC[k][39:32]);
        default: peek(VEC[k][31:24], VEC[k][23:0], $sformatf("R%0d", VEC[k][47:44]));
      endcase
    end

    // R6: reads return zero
    for (int a = 0; a < 16; a += 4) begin
      @(negedge clk);
      rd_en = 1; addr = a[3:0];
      #1;
      chk("R6", rdata, 32'h0);
    end
    @(negedge clk);
    rd_en = 0;

    // R1: offsets 0x8 and 0xC ignored mid-triple
    wr(4'h0, 8'h40);
    wr(4'h4, 8'h71);
    wr(4'h8, 8'h99);
    wr(4'hC, 8'h98);
    wr(4'h4, 8'h72);
    wr(4'h4, 8'h73);
    peek(8'h40, 24'h717273, "R1");
    peek(8'h41, 24'h000000, "R1");
    peek(8'h99, 24'h000000, "R1");

    // R8: not visible before the edge, visible right after it
    wr(4'h0, 8'h50);
    pix_idx = 8'h50;
    @(negedge clk);
    wr_en = 1; addr = 4'h4; wdata = {8'hE7, 24'h0};
    #1;
    chk("R8", {8'h0, pix_rgb}, 32'h0);
    @(posedge clk);
    #1;
    chk("R8", {8'h0, pix_rgb}, 32'hE70000);
    @(negedge clk);
    wr_en = 0;

    // R4: wrap 255 -> 0
    wr(4'h0, 8'hFF);
    wr(4'h4, 8'h09); wr(4'h4, 8'h08); wr(4'h4, 8'h07);
    wr(4'h4, 8'h01); wr(4'h4, 8'h02); wr(4'h4, 8'h03);
    peek(8'hFF, 24'h090807, "R4");
    peek(8'h00, 24'h010203, "R4");

    // R2: low bits of index word ignored
    @(negedge clk);
    wr_en = 1; addr = 4'h0; wdata = 32'h60FFFFFF;
    @(negedge clk);
    wr_en = 0;
    wr(4'h4, 8'h0A); wr(4'h4, 8'h0B); wr(4'h4, 8'h0C);
    peek(8'h60, 24'h0A0B0C, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule